// File: doc/BRIEF.md
# Inter-Processor Interrupt Routing Frame

This block is the register frame one local processor uses for one protocol of an inter-processor interrupt router. Remote clients each own a small group of signal lines. A one-cycle pulse on any line latches a pending bit for that client/signal pair. Software controls the frame through a plain read/write register bus. It never handles bitmasks. Every enable, disable, acknowledge and send names a single pair through a packed 32-bit identifier, with the client in the upper half and the signal in the lower half.

While any pending pair is also enabled, the frame holds a single level-high interrupt line. The interrupt handler reads the receive register to get the identifier of the next pending, enabled pair. It services that pair and writes the same identifier to the acknowledge register. It repeats this until the read returns all ones. To raise an interrupt at a remote client, software writes an identifier to the send register. The frame then emits a one-cycle outbound pulse tagged with the client and signal. A client-clear write returns all receive state to its reset condition.

Top module: `irq_route_frame`

## Requirements
- R1: After reset, `irq_out`, `send_valid` and `bus_rdata` are 0, and every pair is disabled, so a pending pair raises no interrupt until it is enabled.
- R2: An identifier carries the client number in bits 31:16 and the signal number in bits 15:0. Pair (c, s) uses inbound line `sig_in[c*NUM_SIGNALS + s]`.
- R3: A pulse on an inbound line sets that pair's pending bit, which stays set until it is cleared. `irq_out` is 1 in the cycle after any edge that leaves an enabled pair pending, and 0 otherwise.
- R4: A read of offset 0x10 returns the identifier of the pending, enabled pair with the lowest client number, and the lowest signal number within that client. It returns 0xFFFFFFFF when no such pair exists.
- R5: Writing an identifier to offset 0x1C clears only that pair's pending bit. If an inbound pulse for the same pair arrives in the same cycle, the pair stays pending.
- R6: Writing an identifier to offset 0x14 enables only that pair, and writing it to offset 0x18 disables only that pair. A disabled pair keeps its pending bit, and that bit is reported again once the pair is re-enabled.
- R7: Writing an identifier to offset 0x0C produces `send_valid` for exactly one cycle, in the cycle after the write, with `send_client` and `send_signal` taken from the identifier.
- R8: Writing a value with bit 0 set to offset 0x38 clears every pending bit and disables every pair. A pulse arriving in the same cycle is also dropped. A value with bit 0 clear has no effect.
- R9: An identifier whose client is at least `NUM_CLIENTS`, or whose signal is at least `NUM_SIGNALS`, is ignored by the enable, disable, acknowledge and send registers.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_rd_en`. A read of any offset other than 0x10 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset within the frame |
| bus_wdata | input | 32 | Write data, usually a packed identifier |
| bus_rdata | output | 32 | Registered read data |
| sig_in | input | NUM_CLIENTS*NUM_SIGNALS | Inbound one-cycle signal pulses, one per pair |
| irq_out | output | 1 | Level-high interrupt to the local processor |
| send_valid | output | 1 | One-cycle outbound interrupt strobe |
| send_client | output | 16 | Target client of the outbound interrupt |
| send_signal | output | 16 | Target signal of the outbound interrupt |

## Verification
The receive register is exercised with these cases:
- A single enabled pair, to confirm the identifier packing.
- Pairs in two different clients, to check that the lower client wins.
- Two signals of one client, to check that the lower signal wins.
- Pending pairs that are masked, which must stay hidden, and then reappear once unmasked.

An acknowledge that coincides with a new pulse is set apart from an ordinary acknowledge. Identifiers with a signal just past the range are used on purpose: if the range check were missing, they would alias onto a neighbouring client's line. The client-clear register is written with bit 0 low and then high, to separate the real reset of receive state from a harmless write.

// File: rtl/ipc_frame_pkg.sv
package ipc_frame_pkg;
  localparam int ID_W        = 32;
  localparam int FIELD_W     = 16;
  localparam int OFF_SEND    = 'h0C;
  localparam int OFF_RECV    = 'h10;
  localparam int OFF_ENABLE  = 'h14;
  localparam int OFF_DISABLE = 'h18;
  localparam int OFF_ACK     = 'h1C;
  localparam int OFF_CCLEAR  = 'h38;
  localparam logic [ID_W-1:0] ID_NONE = '1;
endpackage

// File: rtl/frame_id_decode.sv
module frame_id_decode
  import ipc_frame_pkg::*;
#(
  parameter int NUM_CLIENTS = 17,
  parameter int NUM_SIGNALS = 4,
  localparam int NUM_LINES  = NUM_CLIENTS * NUM_SIGNALS
) (
  input  logic [ID_W-1:0]      id,
  output logic [NUM_LINES-1:0] onehot
);
  logic [FIELD_W-1:0] client_f;
  logic [FIELD_W-1:0] signal_f;

  assign client_f = id[ID_W-1:FIELD_W];
  assign signal_f = id[FIELD_W-1:0];

  // Out-of-range fields match no line, so the whole vector stays zero.
  for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_client
    for (genvar s = 0; s < NUM_SIGNALS; s++) begin : g_signal
      assign onehot[c*NUM_SIGNALS + s] =
        (client_f == FIELD_W'(c)) && (signal_f == FIELD_W'(s));
    end
  end
endmodule

// File: rtl/frame_pending_bank.sv
module frame_pending_bank #(
  parameter int NUM_LINES = 68
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] sig_in,
  input  logic [NUM_LINES-1:0] en_hit,
  input  logic [NUM_LINES-1:0] dis_hit,
  input  logic [NUM_LINES-1:0] ack_hit,
  input  logic                 clear_all,
  output logic [NUM_LINES-1:0] live_q,
  output logic                 any_live_d
);
  logic [NUM_LINES-1:0] pend_q, pend_d;
  logic [NUM_LINES-1:0] en_q, en_d;

  always_comb begin
    if (clear_all) begin
      pend_d = '0;
      en_d   = '0;
    end else begin
      pend_d = (pend_q & ~ack_hit) | sig_in;  // new pulse beats acknowledge
      en_d   = (en_q & ~dis_hit) | en_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  assign live_q     = pend_q & en_q;
  assign any_live_d = |(pend_d & en_d);
endmodule

// File: rtl/frame_pick_first.sv
module frame_pick_first
  import ipc_frame_pkg::*;
#(
  parameter int NUM_CLIENTS = 17,
  parameter int NUM_SIGNALS = 4,
  localparam int NUM_LINES  = NUM_CLIENTS * NUM_SIGNALS
) (
  input  logic [NUM_LINES-1:0] live,
  output logic [ID_W-1:0]      first_id
);
  // Line index grows with client then signal, so the lowest set index wins.
  always_comb begin
    first_id = ID_NONE;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (live[i]) begin
        first_id = {FIELD_W'(i / NUM_SIGNALS), FIELD_W'(i % NUM_SIGNALS)};
      end
    end
  end
endmodule

// File: rtl/frame_send_port.sv
module frame_send_port
  import ipc_frame_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [ID_W-1:0]    id,
  output logic               send_valid,
  output logic [FIELD_W-1:0] send_client,
  output logic [FIELD_W-1:0] send_signal
);
  always_ff @(posedge clk) begin
    if (rst) begin
      send_valid  <= 1'b0;
      send_client <= '0;
      send_signal <= '0;
    end else begin
      send_valid <= fire;
      if (fire) begin
        send_client <= id[ID_W-1:FIELD_W];
        send_signal <= id[FIELD_W-1:0];
      end
    end
  end
endmodule

// File: rtl/irq_route_frame.sv
module irq_route_frame
  import ipc_frame_pkg::*;
#(
  parameter int NUM_CLIENTS = 17,
  parameter int NUM_SIGNALS = 4,
  parameter int ADDR_W      = 8,
  localparam int NUM_LINES  = NUM_CLIENTS * NUM_SIGNALS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr_en,
  input  logic                 bus_rd_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [ID_W-1:0]      bus_wdata,
  output logic [ID_W-1:0]      bus_rdata,
  input  logic [NUM_LINES-1:0] sig_in,
  output logic                 irq_out,
  output logic                 send_valid,
  output logic [FIELD_W-1:0]   send_client,
  output logic [FIELD_W-1:0]   send_signal
);
  logic [NUM_LINES-1:0] id_hit;
  logic [NUM_LINES-1:0] live_q;
  logic                 any_live_d;
  logic [ID_W-1:0]      first_id;
  logic                 wr_send, wr_en_reg, wr_dis_reg, wr_ack_reg, wr_cclr;
  logic                 rd_recv;

  assign wr_send    = bus_wr_en && (bus_addr == ADDR_W'(OFF_SEND));
  assign wr_en_reg  = bus_wr_en && (bus_addr == ADDR_W'(OFF_ENABLE));
  assign wr_dis_reg = bus_wr_en && (bus_addr == ADDR_W'(OFF_DISABLE));
  assign wr_ack_reg = bus_wr_en && (bus_addr == ADDR_W'(OFF_ACK));
  assign wr_cclr    = bus_wr_en && (bus_addr == ADDR_W'(OFF_CCLEAR)) && bus_wdata[0];
  assign rd_recv    = (bus_addr == ADDR_W'(OFF_RECV));

  frame_id_decode #(
    .NUM_CLIENTS(NUM_CLIENTS),
    .NUM_SIGNALS(NUM_SIGNALS)
  ) u_decode (
    .id    (bus_wdata),
    .onehot(id_hit)
  );

  frame_pending_bank #(
    .NUM_LINES(NUM_LINES)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .sig_in    (sig_in),
    .en_hit    (id_hit & {NUM_LINES{wr_en_reg}}),
    .dis_hit   (id_hit & {NUM_LINES{wr_dis_reg}}),
    .ack_hit   (id_hit & {NUM_LINES{wr_ack_reg}}),
    .clear_all (wr_cclr),
    .live_q    (live_q),
    .any_live_d(any_live_d)
  );

  frame_pick_first #(
    .NUM_CLIENTS(NUM_CLIENTS),
    .NUM_SIGNALS(NUM_SIGNALS)
  ) u_pick (
    .live    (live_q),
    .first_id(first_id)
  );

  frame_send_port u_send (
    .clk        (clk),
    .rst        (rst),
    .fire       (wr_send && (|id_hit)),
    .id         (bus_wdata),
    .send_valid (send_valid),
    .send_client(send_client),
    .send_signal(send_signal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      irq_out   <= any_live_d;
      bus_rdata <= (bus_rd_en && rd_recv) ? first_id : '0;
    end
  end
endmodule

// File: rtl/irq_route_frame_checker.sv
module irq_route_frame_checker
  import ipc_frame_pkg::*;
#(
  parameter int NUM_CLIENTS = 17,
  parameter int NUM_SIGNALS = 4,
  parameter int ADDR_W      = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr_en,
  input logic               bus_rd_en,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [ID_W-1:0]    bus_wdata,
  input logic [ID_W-1:0]    bus_rdata,
  input logic               irq_out,
  input logic               send_valid,
  input logic [FIELD_W-1:0] send_client,
  input logic [FIELD_W-1:0] send_signal
);
  AST_SEND_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    send_valid |-> $past(bus_wr_en && bus_addr == ADDR_W'(OFF_SEND))); // R7

  AST_SEND_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    send_valid |-> (send_client < FIELD_W'(NUM_CLIENTS)) && (send_signal < FIELD_W'(NUM_SIGNALS))); // R9

  AST_RECV_ID_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd_en && bus_addr == ADDR_W'(OFF_RECV)) && bus_rdata != ID_NONE)
    |-> (bus_rdata[ID_W-1:FIELD_W] < FIELD_W'(NUM_CLIENTS)) &&
        (bus_rdata[FIELD_W-1:0] < FIELD_W'(NUM_SIGNALS))); // R4

  AST_RECV_NONE_MEANS_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd_en && bus_addr == ADDR_W'(OFF_RECV)) && bus_rdata == ID_NONE)
    |-> !$past(irq_out)); // R3

  AST_RECV_ID_MEANS_IRQ: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd_en && bus_addr == ADDR_W'(OFF_RECV)) && bus_rdata != ID_NONE)
    |-> $past(irq_out)); // R3

  AST_CCLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr_en && bus_addr == ADDR_W'(OFF_CCLEAR) && bus_wdata[0]) |-> !irq_out); // R8

  AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd_en && bus_addr != ADDR_W'(OFF_RECV)) |-> bus_rdata == '0); // R10
endmodule

bind irq_route_frame irq_route_frame_checker #(
  .NUM_CLIENTS(NUM_CLIENTS),
  .NUM_SIGNALS(NUM_SIGNALS),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr_en  (bus_wr_en),
  .bus_rd_en  (bus_rd_en),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq_out    (irq_out),
  .send_valid (send_valid),
  .send_client(send_client),
  .send_signal(send_signal)
);

// File: tb/irq_route_frame_tb.sv
module irq_route_frame_tb;
  localparam int NC = 17;
  localparam int NS = 4;
  localparam int NL = NC * NS;
  localparam int AW = 8;
  localparam logic [31:0] NONE = 32'hFFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [31:0]   wdata, rdata;
  logic [NL-1:0] sig_in;
  logic          irq, sv;
  logic [15:0]   sc, ss;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #5 clk = ~clk;

  irq_route_frame #(.NUM_CLIENTS(NC), .NUM_SIGNALS(NS), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .sig_in(sig_in),
    .irq_out(irq), .send_valid(sv), .send_client(sc), .send_signal(ss)
  );

  function automatic logic [31:0] pid(int c, int s);
    return {c[15:0], s[15:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: read data lands the cycle after the strobe.
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: unexpected read data %h expected none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic bus_write(int off, logic [31:0] d);
    wr_en = 1'b1; addr = AW'(off); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(int off, logic [31:0] exp, string tag);
    rd_en = 1'b1; addr = AW'(off);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(int c, int s);
    sig_in[c*NS + s] = 1'b1;
    @(negedge clk);
    sig_in = '0;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; sig_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq after reset", 32'(irq), 0);
    check("R1 send_valid after reset", 32'(sv), 0);
    check("R1 rdata after reset", rdata, 0);
    bus_read('h10, NONE, "R4 nothing pending");

    // Disabled by default: pending stays hidden.
    pulse(3, 1);
    check("R1 pending but disabled, irq", 32'(irq), 0);
    bus_read('h10, NONE, "R1 disabled pair hidden");

    bus_write('h14, pid(3, 1));
    check("R3 irq after enable", 32'(irq), 1);
    bus_read('h10, pid(3, 1), "R2 packed id of pair 3/1");

    // Client priority then signal priority.
    bus_write('h14, pid(0, 2));
    pulse(0, 2);
    bus_write('h14, pid(3, 0));
    pulse(3, 0);
    bus_read('h10, pid(0, 2), "R4 lowest client first");
    bus_write('h1C, pid(0, 2));
    bus_read('h10, pid(3, 0), "R4 lowest signal within client");
    bus_write('h1C, pid(3, 0));
    bus_read('h10, pid(3, 1), "R5 only named pair cleared");

    // Mask keeps pending.
    bus_write('h18, pid(3, 1));
    check("R6 irq after disable", 32'(irq), 0);
    bus_read('h10, NONE, "R6 disabled pair hidden");
    bus_write('h14, pid(3, 1));
    check("R6 irq after re-enable", 32'(irq), 1);

    // Acknowledge colliding with a new pulse.
    sig_in[3*NS + 1] = 1'b1;
    bus_write('h1C, pid(3, 1));
    sig_in = '0;
    bus_read('h10, pid(3, 1), "R5 pulse beats same-cycle clear");
    bus_write('h1C, pid(3, 1));
    check("R5 irq after clear", 32'(irq), 0);
    bus_read('h10, NONE, "R5 loop ends with all ones");

    // Out-of-range identifiers (2,4 would alias line of 3,0).
    bus_write('h18, pid(3, 0));
    pulse(3, 0);
    bus_write('h14, pid(2, 4));
    check("R9 out-of-range signal enable ignored", 32'(irq), 0);
    bus_write('h14, pid(17, 0));
    check("R9 out-of-range client enable ignored", 32'(irq), 0);
    bus_read('h10, NONE, "R9 nothing enabled");
    bus_write('h0C, pid(17, 1));
    check("R9 out-of-range send ignored", 32'(sv), 0);

    // Send pulse.
    bus_write('h0C, pid(16, 3));
    check("R7 send_valid", 32'(sv), 1);
    check("R7 send_client", 32'(sc), 16);
    check("R7 send_signal", 32'(ss), 3);
    @(negedge clk);
    check("R7 send_valid one cycle", 32'(sv), 0);

    // Other offsets read as zero.
    bus_read('h0C, 0, "R10 send reg reads zero");
    bus_read('h14, 0, "R10 enable reg reads zero");

    // Highest pair, order within last client.
    bus_write('h14, pid(16, 3));
    bus_write('h14, pid(16, 0));
    pulse(16, 3);
    bus_read('h10, pid(16, 3), "R4 highest pair");
    pulse(16, 0);
    bus_read('h10, pid(16, 0), "R4 signal 0 before 3");

    // Client clear.
    bus_write('h38, 0);
    check("R8 bit0 low no effect", 32'(irq), 1);
    bus_write('h38, 1);
    check("R8 irq after client clear", 32'(irq), 0);
    bus_read('h10, NONE, "R8 pending cleared");
    pulse(16, 3);
    check("R8 enables reset", 32'(irq), 0);
    bus_write('h14, pid(3, 0));
    check("R8 old pending of 3/0 gone", 32'(irq), 0);

    repeat (3) @(negedge clk);
    check("R10 scoreboard drained", 32'(exp_q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule